// File: doc/BRIEF.md
# Eight-bit ALU with status flags

A purely combinational arithmetic and logic unit for a small accumulator-style processor core. Each cycle the core presents a four-bit operation code, an accumulator operand, a memory operand and the current carry flag. The unit returns a result byte, a write-back enable for that byte, and new values for the carry, zero, overflow and negative flags. Each flag has its own update enable, so the core knows which flags the operation touched and which it must keep.

Arithmetic is binary only. Subtraction and comparison treat carry as the inverse of borrow, so multi-byte subtraction can chain through the carry flag. Compare and bit test set flags but produce no result to write back. Registers, operand routing and sequencing belong to the surrounding core. For increment and decrement of an index register, the core routes that register through the memory operand.

When an output is not enabled it is driven to 0. The core can therefore OR or mux the outputs without qualifying them first.

Top module: `alu8`

## Requirements
- R1: Operation codes are 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 bit test, 7 increment, 8 decrement, 9 shift left, 10 logical shift right, 11 rotate left, 12 rotate right. `res_we` is 1 exactly for codes 0, 1, 3, 4, 5 and 7 to 12, and `res_out` is 0 whenever `res_we` is 0.
- R2: Add gives `res_out` = (a_in + m_in + c_in) mod 256 and `c_out` = 1 when that sum exceeds 255. `v_out` = 1 when the signed sum lies outside -128..127. C, Z, V and N are all enabled.
- R3: Subtract gives `res_out` = (a_in - m_in - (1 - c_in)) mod 256 and `c_out` = 1 when no borrow occurs (the difference is 0 or more). `v_out` = 1 when the signed difference lies outside -128..127. C, Z, V and N are all enabled.
- R4: Compare enables only C, Z and N. It sets `c_out` when a_in >= m_in unsigned, sets `z_out` when they are equal, and sets `n_out` to bit 7 of (a_in - m_in) mod 256. It ignores `c_in` and writes no result.
- R5: AND, OR and XOR return the bitwise function of a_in and m_in and enable only Z and N.
- R6: Bit test enables only Z, V and N. `z_out` is 1 when (a_in AND m_in) is 0, `n_out` equals m_in bit 7, and `v_out` equals m_in bit 6.
- R7: Increment and decrement return m_in + 1 or m_in - 1 (mod 256), wrapping 255 to 0 and 0 to 255. They enable only Z and N, so carry and overflow are left untouched.
- R8: Shift left returns a_in with bits moved up and 0 entering bit 0. Logical shift right returns a_in with bits moved down and 0 entering bit 7. The bit shifted out goes to `c_out`. C, Z and N are enabled.
- R9: Rotate left fills bit 0 from `c_in`, and rotate right fills bit 7 from `c_in`. The bit shifted out of a_in goes to `c_out`. C, Z and N are enabled.
- R10: Whenever a result is written, `z_out` is 1 exactly when `res_out` is 0 and `n_out` equals `res_out` bit 7. Every flag output whose enable is 0 reads 0.
- R11: Codes 13 to 15 assert no enable and drive every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| a_in | input | 8 | Accumulator operand |
| m_in | input | 8 | Memory operand |
| c_in | input | 1 | Incoming carry flag |
| res_out | output | 8 | Result byte |
| res_we | output | 1 | Result write-back enable |
| c_out | output | 1 | New carry flag |
| c_we | output | 1 | Carry update enable |
| z_out | output | 1 | New zero flag |
| z_we | output | 1 | Zero update enable |
| v_out | output | 1 | New overflow flag |
| v_we | output | 1 | Overflow update enable |
| n_out | output | 1 | New negative flag |
| n_we | output | 1 | Negative update enable |

## Verification
Every operation code is tried with operand pairs drawn from a grid that includes 0x00, 0x01, 0x7F, 0x80 and 0xFF, each pair with both values of the incoming carry. The grid's sign-boundary values separate overflow from carry in add and subtract, and equal operands separate the zero and carry results of compare. The wrap points separate correct increment and decrement from a missing enable. Patterns with bits 6 and 7 set alone separate bit test's flags from the AND result, and toggling the incoming carry tells rotates apart from plain shifts.

// File: rtl/alu8.sv
module alu8 #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] m_in,
  input  logic         c_in,
  output logic [W-1:0] res_out,
  output logic         res_we,
  output logic         c_out,
  output logic         c_we,
  output logic         z_out,
  output logic         z_we,
  output logic         v_out,
  output logic         v_we,
  output logic         n_out,
  output logic         n_we
);
  localparam logic [3:0] OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_CMP = 4'd2,
                         OP_AND = 4'd3,  OP_OR  = 4'd4,  OP_XOR = 4'd5,
                         OP_BIT = 4'd6,  OP_INC = 4'd7,  OP_DEC = 4'd8,
                         OP_SHL = 4'd9,  OP_SHR = 4'd10, OP_ROL = 4'd11,
                         OP_ROR = 4'd12;
  localparam int MSB = W - 1;

  logic [W:0]   sum, dif, cmp;
  logic [W-1:0] r;

  assign sum = {1'b0, a_in} + {1'b0, m_in} + {{W{1'b0}}, c_in};
  assign dif = {1'b0, a_in} + {1'b0, ~m_in} + {{W{1'b0}}, c_in};
  assign cmp = {1'b0, a_in} + {1'b0, ~m_in} + {{W{1'b0}}, 1'b1};

  always_comb begin
    r      = '0;
    res_we = 1'b0;
    c_out  = 1'b0; c_we = 1'b0;
    z_out  = 1'b0; z_we = 1'b0;
    v_out  = 1'b0; v_we = 1'b0;
    n_out  = 1'b0; n_we = 1'b0;
    case (op)
      OP_ADD: begin
        r = sum[MSB:0]; res_we = 1'b1;
        c_out = sum[W]; c_we = 1'b1;
        v_out = ~(a_in[MSB] ^ m_in[MSB]) & (a_in[MSB] ^ sum[MSB]); v_we = 1'b1;
      end
      OP_SUB: begin
        r = dif[MSB:0]; res_we = 1'b1;
        c_out = dif[W]; c_we = 1'b1;
        v_out = (a_in[MSB] ^ m_in[MSB]) & (a_in[MSB] ^ dif[MSB]); v_we = 1'b1;
      end
      OP_CMP: begin
        c_out = cmp[W]; c_we = 1'b1;
        z_out = (cmp[MSB:0] == '0); z_we = 1'b1;
        n_out = cmp[MSB]; n_we = 1'b1;
      end
      OP_AND: begin r = a_in & m_in; res_we = 1'b1; end
      OP_OR:  begin r = a_in | m_in; res_we = 1'b1; end
      OP_XOR: begin r = a_in ^ m_in; res_we = 1'b1; end
      OP_BIT: begin
        z_out = ((a_in & m_in) == '0); z_we = 1'b1;
        n_out = m_in[MSB]; n_we = 1'b1;
        v_out = m_in[MSB-1]; v_we = 1'b1;
      end
      OP_INC: begin r = m_in + 1'b1; res_we = 1'b1; end
      OP_DEC: begin r = m_in - 1'b1; res_we = 1'b1; end
      OP_SHL: begin
        r = {a_in[MSB-1:0], 1'b0}; res_we = 1'b1;
        c_out = a_in[MSB]; c_we = 1'b1;
      end
      OP_SHR: begin
        r = {1'b0, a_in[MSB:1]}; res_we = 1'b1;
        c_out = a_in[0]; c_we = 1'b1;
      end
      OP_ROL: begin
        r = {a_in[MSB-1:0], c_in}; res_we = 1'b1;
        c_out = a_in[MSB]; c_we = 1'b1;
      end
      OP_ROR: begin
        r = {c_in, a_in[MSB:1]}; res_we = 1'b1;
        c_out = a_in[0]; c_we = 1'b1;
      end
      default: ;
    endcase
    if (res_we) begin
      z_out = (r == '0); z_we = 1'b1;
      n_out = r[MSB];    n_we = 1'b1;
    end
  end

  assign res_out = r;
endmodule

module alu8_props #(
  parameter int W = 8
) (
  input logic [3:0]   op,
  input logic [W-1:0] a_in,
  input logic [W-1:0] m_in,
  input logic         c_in,
  input logic [W-1:0] res_out,
  input logic         res_we,
  input logic         c_out,
  input logic         c_we,
  input logic         z_out,
  input logic         z_we,
  input logic         v_out,
  input logic         v_we,
  input logic         n_out,
  input logic         n_we
);
  always_comb begin
    // R1
    no_result_zero_chk: assert (res_we || res_out == '0);
    // R2
    add_sum_chk: assert (op != 4'd0 || ({c_out, res_out} == ({1'b0, a_in} + {1'b0, m_in} + {{W{1'b0}}, c_in})));
    // R4
    cmp_order_chk: assert (op != 4'd2 || (!res_we && c_out == (a_in >= m_in) && z_out == (a_in == m_in)));
    // R6
    bit_flags_chk: assert (op != 4'd6 || (!res_we && n_out == m_in[W-1] && v_out == m_in[W-2]));
    // R7
    incdec_keep_chk: assert (!(op == 4'd7 || op == 4'd8) || (!c_we && !v_we));
    // R10
    zn_result_chk: assert (!res_we || (z_out == (res_out == '0) && n_out == res_out[W-1]));
    // R10
    idle_flag_chk: assert ((c_we || !c_out) && (z_we || !z_out) && (v_we || !v_out) && (n_we || !n_out));
    // R11
    spare_code_chk: assert (op < 4'd13 || !(res_we | c_we | z_we | v_we | n_we));
  end
endmodule

bind alu8 alu8_props #(.W(W)) u_props (.*);

// File: tb/sim_alu8.sv
module sim_alu8;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] op;
  logic [7:0] a_in, m_in, res_out;
  logic c_in, res_we, c_out, c_we, z_out, z_we, v_out, v_we, n_out, n_we;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  alu8 u0 (.op(op), .a_in(a_in), .m_in(m_in), .c_in(c_in),
           .res_out(res_out), .res_we(res_we), .c_out(c_out), .c_we(c_we),
           .z_out(z_out), .z_we(z_we), .v_out(v_out), .v_we(v_we),
           .n_out(n_out), .n_we(n_we));

  function automatic string req_of(int o);
    case (o)
      0: return "R2"; 1: return "R3"; 2: return "R4";
      3, 4, 5: return "R5"; 6: return "R6"; 7, 8: return "R7";
      9, 10: return "R8"; 11, 12: return "R9";
      default: return "R11";
    endcase
  endfunction

  // expected {res[7:0], res_we, c, c_we, z, z_we, v, v_we, n, n_we}
  function automatic logic [16:0] model(int o, int a, int m, int c);
    int r = 0, we = 0, cf = 0, cw = 0, zf = 0, zw = 0, vf = 0, vw = 0, nf = 0, nw = 0;
    int sa = (a > 127) ? a - 256 : a;
    int sm = (m > 127) ? m - 256 : m;
    int t;
    case (o)
      0: begin t = a + m + c; r = t % 256; we = 1; cf = (t > 255); cw = 1;
               t = sa + sm + c; vf = (t > 127 || t < -128); vw = 1; end
      1: begin t = a - m - (1 - c); r = (t + 256) % 256; we = 1; cf = (t >= 0); cw = 1;
               t = sa - sm - (1 - c); vf = (t > 127 || t < -128); vw = 1; end
      2: begin t = (a - m + 256) % 256; cf = (a >= m); cw = 1;
               zf = (a == m); zw = 1; nf = t / 128; nw = 1; end
      3: begin r = a & m; we = 1; end
      4: begin r = a | m; we = 1; end
      5: begin r = a ^ m; we = 1; end
      6: begin zf = ((a & m) == 0); zw = 1; nf = (m / 128) % 2; nw = 1;
               vf = (m / 64) % 2; vw = 1; end
      7: begin r = (m + 1) % 256; we = 1; end
      8: begin r = (m + 255) % 256; we = 1; end
      9:  begin r = (a * 2) % 256; we = 1; cf = a / 128; cw = 1; end
      10: begin r = a / 2; we = 1; cf = a % 2; cw = 1; end
      11: begin r = (a * 2) % 256 + c; we = 1; cf = a / 128; cw = 1; end
      12: begin r = a / 2 + 128 * c; we = 1; cf = a % 2; cw = 1; end
      default: ;
    endcase
    if (we != 0) begin zf = (r == 0); zw = 1; nf = r / 128; nw = 1; end
    return {r[7:0], we[0], cf[0], cw[0], zf[0], zw[0], vf[0], vw[0], nf[0], nw[0]};
  endfunction

  task automatic apply(int o, int a, int m, int c, string tag);
    logic [16:0] exp_v, got;
    @(posedge clk);
    op = o[3:0]; a_in = a[7:0]; m_in = m[7:0]; c_in = c[0];
    @(negedge clk);
    exp_v = model(o, a, m, c);
    got = {res_out, res_we, c_out, c_we, z_out, z_we, v_out, v_we, n_out, n_we};
    checks++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s op=%0d a=%h m=%h c=%0d actual=%h expected=%h",
               tag, o, a, m, c, got, exp_v);
    end
  endtask

  int vals[17] = '{0, 1, 2, 15, 63, 64, 65, 126, 127, 128, 129, 170, 85, 192, 253, 254, 255};

  initial begin
    op = 4'd13; a_in = 8'h00; m_in = 8'h00; c_in = 1'b0;
    // R11 idle state with a spare code
    apply(13, 0, 0, 0, "R11");
    // R1 enables and zeroed result for non-writing codes
    apply(2, 8'h55, 8'h55, 1, "R1");
    apply(6, 8'hFF, 8'hC0, 0, "R1");
    // R2 signed overflow without carry, and carry without overflow
    apply(0, 8'h7F, 8'h01, 0, "R2");
    apply(0, 8'h80, 8'h80, 0, "R2");
    apply(0, 8'hFF, 8'h00, 1, "R2");
    // R3 borrow and signed overflow
    apply(1, 8'h00, 8'h01, 1, "R3");
    apply(1, 8'h80, 8'h01, 1, "R3");
    apply(1, 8'h05, 8'h05, 0, "R3");
    // R4 compare ignores carry
    apply(2, 8'h10, 8'h20, 1, "R4");
    // R6 N and V from memory operand only
    apply(6, 8'h00, 8'h40, 0, "R6");
    // R7 wrap points
    apply(7, 8'h00, 8'hFF, 1, "R7");
    apply(8, 8'h00, 8'h00, 1, "R7");
    // R8 and R9 carry fill
    apply(9, 8'h80, 8'h00, 1, "R8");
    apply(10, 8'h01, 8'h00, 1, "R8");
    apply(11, 8'h80, 8'h00, 1, "R9");
    apply(12, 8'h01, 8'h00, 1, "R9");
    // R10 sweep of every code over the operand grid
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 17; i++)
        for (int j = 0; j < 17; j++)
          for (int c = 0; c < 2; c++)
            apply(o, vals[i], vals[j], c, req_of(o));
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule